// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides one integer by another over several clock cycles. A caller presents a dividend, a divisor and a mode select, then pulses `start`. Over the following cycles the block works through one quotient bit per clock. When it finishes, the quotient appears on `lo` and the remainder on `hi`, and `done` is pulsed for one cycle. The mode select picks signed division, which truncates toward zero, or unsigned division of the raw bit patterns.

Internally the block keeps a single combined register. Its upper part holds a signed partial remainder one bit wider than the operands, and its lower part is the quotient shift register. In each step the combined register moves one place left. The divisor is then added to or subtracted from the upper part, chosen by the sign that part had before the step. The complement of the new sign becomes the next quotient bit. The partial remainder is never restored inside the loop. A single correction cycle at the end adds the divisor back if the upper part is still negative. Signed operands are first reduced to magnitudes, and the results are negated afterwards where the operand signs require it.

Top module: `seq_nr_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: With `signed_op` = 0, `lo` receives floor(dividend / divisor) and `hi` receives dividend mod divisor, with both operands read as unsigned values.
- R3: With `signed_op` = 1, both operands are read as two's complement. `lo` receives the quotient truncated toward zero, so it is negative exactly when the operand signs differ. The most negative dividend divided by -1 yields the most negative value on `lo`.
- R4: With `signed_op` = 1, a nonzero remainder on `hi` carries the sign of the dividend, and its magnitude is less than the divisor's magnitude.
- R5: A zero divisor, in either mode, completes with normal timing. It leaves `lo` all ones and `hi` equal to the dividend.
- R6: A `start` seen at a clock edge while `busy` is 0 is accepted. `busy` is 1 from that edge until the 33rd following edge. At that 33rd edge `done` rises, and it stays high for exactly one cycle.
- R7: A `start` seen while `busy` is 1 is ignored. The operation in flight finishes with its own operands and timing.
- R8: `hi` and `lo` change only at the edge where `done` rises, and they hold their values between completions.
- R9: `busy` and `done` are never high together. A `start` presented during the `done` cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division, sampled when idle |
| signed_op | input | 1 | 1 selects two's-complement division, 0 unsigned |
| dividend | input | W | Dividend, captured with an accepted start |
| divisor | input | W | Divisor, captured with an accepted start |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when a result has been written |
| hi | output | W | Remainder of the last completed division |
| lo | output | W | Quotient of the last completed division |

## Verification
The hardest situation to reach is a new request that meets the divider at a boundary of its own timeline. One case is a `start` held up in the middle of an operation with different operands. The other is a `start` arriving in the single cycle when `done` is high. The bench schedules both cases directly from the model's view of the cycle count, then checks that the result on the ports belongs to the right operation. Signed corner values also need deliberate stimulus: the most negative dividend, a divisor of -1 and a zero divisor. These are driven explicitly, and a generated sequence of operand pairs with widely spread divisor sizes is run alongside them.

// File: rtl/nrdiv_pkg.sv
`timescale 1ns/1ps
package nrdiv_pkg;

   typedef enum logic [1:0] {
      NR_IDLE = 2'd0,
      NR_ITER = 2'd1,
      NR_FIX  = 2'd2
   } nr_state_t;

   // cycles from the accepting edge to the edge that raises done
   function automatic int nr_latency(input int width);
      return width + 1;
   endfunction

endpackage

// File: rtl/nrdiv_operand_prep.sv
`timescale 1ns/1ps
module nrdiv_operand_prep #(
   parameter int W          = 32,
   parameter bit HAS_SIGNED = 1'b1
) (
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   input  logic         signed_op,
   output logic [W-1:0] dvd_mag,
   output logic [W-1:0] dvs_mag,
   output logic         neg_quo,
   output logic         neg_rem
);

   generate
      if (HAS_SIGNED) begin : g_signed
         logic dvd_neg;
         logic dvs_neg;
         always_comb begin
            dvd_neg = signed_op & dividend[W-1];
            dvs_neg = signed_op & divisor[W-1];
            dvd_mag = dvd_neg ? (~dividend + 1'b1) : dividend;
            dvs_mag = dvs_neg ? (~divisor + 1'b1) : divisor;
            neg_quo = dvd_neg ^ dvs_neg;
            neg_rem = dvd_neg;
         end
      end else begin : g_unsigned
         logic unused_mode;
         always_comb begin
            unused_mode = signed_op;
            dvd_mag     = dividend;
            dvs_mag     = divisor;
            neg_quo     = 1'b0;
            neg_rem     = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/nrdiv_step.sv
`timescale 1ns/1ps
module nrdiv_step #(
   parameter int W = 32
) (
   input  logic [W:0]   acc,
   input  logic [W-1:0] quo,
   input  logic [W-1:0] dvs,
   output logic [W:0]   acc_next,
   output logic [W-1:0] quo_next
);

   localparam int AW = W + 1;

   logic [AW-1:0] shifted;
   logic [AW-1:0] dvs_ext;

   always_comb begin
      shifted  = {acc[W-1:0], quo[W-1]};
      dvs_ext  = {1'b0, dvs};
      // previous sign decides between add and subtract, never restore here
      acc_next = acc[W] ? (shifted + dvs_ext) : (shifted - dvs_ext);
      quo_next = {quo[W-2:0], ~acc_next[W]};
   end

endmodule

// File: rtl/nrdiv_finish.sv
`timescale 1ns/1ps
module nrdiv_finish #(
   parameter int W = 32
) (
   input  logic [W:0]   acc,
   input  logic [W-1:0] quo,
   input  logic [W-1:0] dvs,
   input  logic         dvs_zero,
   input  logic         neg_quo,
   input  logic         neg_rem,
   output logic [W-1:0] quo_out,
   output logic [W-1:0] rem_out
);

   logic [W-1:0] rem_mag;

   always_comb begin
      // single correction: the true remainder lies in [0, dvs) so W bits suffice
      rem_mag = acc[W] ? (acc[W-1:0] + dvs) : acc[W-1:0];
      if (dvs_zero)
         quo_out = '1;
      else if (neg_quo)
         quo_out = ~quo + 1'b1;
      else
         quo_out = quo;
      rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
   end

endmodule

// File: rtl/seq_nr_divider.sv
`timescale 1ns/1ps
module seq_nr_divider #(
   parameter int W          = 32,
   parameter bit HAS_SIGNED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         signed_op,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] hi,
   output logic [W-1:0] lo
);
   import nrdiv_pkg::*;

   localparam int CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

   generate
      if (W < 4) begin : g_bad_width
         $error("seq_nr_divider: W must be at least 4");
      end
   endgenerate

   nr_state_t      state_q;
   logic [CNT_W-1:0] step_q;
   logic [W:0]     acc_q;
   logic [W-1:0]   quo_q;
   logic [W-1:0]   dvs_q;
   logic           dvs_zero_q;
   logic           neg_quo_q;
   logic           neg_rem_q;
   logic           done_q;
   logic [W-1:0]   hi_q;
   logic [W-1:0]   lo_q;

   logic [W-1:0]   dvd_mag;
   logic [W-1:0]   dvs_mag;
   logic           neg_quo_in;
   logic           neg_rem_in;
   logic [W:0]     acc_step;
   logic [W-1:0]   quo_step;
   logic [W-1:0]   quo_fin;
   logic [W-1:0]   rem_fin;
   logic           accept;

   nrdiv_operand_prep #(.W(W), .HAS_SIGNED(HAS_SIGNED)) u_prep (
      .dividend  (dividend),
      .divisor   (divisor),
      .signed_op (signed_op),
      .dvd_mag   (dvd_mag),
      .dvs_mag   (dvs_mag),
      .neg_quo   (neg_quo_in),
      .neg_rem   (neg_rem_in)
   );

   nrdiv_step #(.W(W)) u_step (
      .acc      (acc_q),
      .quo      (quo_q),
      .dvs      (dvs_q),
      .acc_next (acc_step),
      .quo_next (quo_step)
   );

   nrdiv_finish #(.W(W)) u_finish (
      .acc      (acc_q),
      .quo      (quo_q),
      .dvs      (dvs_q),
      .dvs_zero (dvs_zero_q),
      .neg_quo  (neg_quo_q),
      .neg_rem  (neg_rem_q),
      .quo_out  (quo_fin),
      .rem_out  (rem_fin)
   );

   assign accept = (state_q == NR_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= NR_IDLE;
         step_q     <= '0;
         acc_q      <= '0;
         quo_q      <= '0;
         dvs_q      <= '0;
         dvs_zero_q <= 1'b0;
         neg_quo_q  <= 1'b0;
         neg_rem_q  <= 1'b0;
         done_q     <= 1'b0;
         hi_q       <= '0;
         lo_q       <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            NR_IDLE: begin
               if (accept) begin
                  acc_q      <= '0;
                  quo_q      <= dvd_mag;
                  dvs_q      <= dvs_mag;
                  dvs_zero_q <= (dvs_mag == '0);
                  neg_quo_q  <= neg_quo_in;
                  neg_rem_q  <= neg_rem_in;
                  step_q     <= '0;
                  state_q    <= NR_ITER;
               end
            end
            NR_ITER: begin
               acc_q  <= acc_step;
               quo_q  <= quo_step;
               step_q <= step_q + 1'b1;
               if (step_q == LAST_STEP)
                  state_q <= NR_FIX;
            end
            NR_FIX: begin
               hi_q    <= rem_fin;
               lo_q    <= quo_fin;
               done_q  <= 1'b1;
               state_q <= NR_IDLE;
            end
            default: state_q <= NR_IDLE;
         endcase
      end
   end

   assign busy = (state_q != NR_IDLE);
   assign done = done_q;
   assign hi   = hi_q;
   assign lo   = lo_q;

endmodule

// File: rtl/nrdiv_checker.sv
`timescale 1ns/1ps
module nrdiv_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] hi,
   input logic [W-1:0] lo
);

   localparam int RUN_W = $clog2(W + 3) + 1;
   localparam logic [RUN_W-1:0] RUN_LEN = RUN_W'(W + 1);

   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_run <= '0;
      else if (busy)
         busy_run <= busy_run + 1'b1;
      else
         busy_run <= '0;
   end

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_accept_raises_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_latency_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_run == RUN_LEN));

   assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RUN_LEN);

   assert_busy_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done) |-> ($stable(hi) && $stable(lo)));

endmodule

bind seq_nr_divider nrdiv_checker #(.W(W)) u_nrdiv_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .hi    (hi),
   .lo    (lo)
);

// File: tb/test_seq_nr_divider.sv
`timescale 1ns/1ps
module test_seq_nr_divider;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         signed_op = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy;
   logic         done;
   logic [W-1:0] hi;
   logic [W-1:0] lo;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur_req = "R1";
   logic [31:0] seed = 32'h1234_5679;

   // reference model state
   logic         m_busy;
   logic         m_done;
   logic [W-1:0] m_hi;
   logic [W-1:0] m_lo;
   logic [W-1:0] p_q;
   logic [W-1:0] p_r;
   int           m_cnt;

   always #2 clk = ~clk;

   seq_nr_divider #(.W(W)) i_seq_nr_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .signed_op (signed_op),
      .dividend  (dividend),
      .divisor   (divisor),
      .busy      (busy),
      .done      (done),
      .hi        (hi),
      .lo        (lo)
   );

   function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic s,
                                   output logic [W-1:0] q, output logic [W-1:0] r);
      longint la;
      longint lb;
      if (b == '0) begin
         q = '1;
         r = a;
      end else begin
         if (s) begin
            la = longint'($signed(a));
            lb = longint'($signed(b));
         end else begin
            la = longint'({32'b0, a});
            lb = longint'({32'b0, b});
         end
         q = W'(la / lb);
         r = W'(la % lb);
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_done <= 1'b0;
         m_hi   <= '0;
         m_lo   <= '0;
         m_cnt  <= 0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_cnt == 1) begin
               m_busy <= 1'b0;
               m_done <= 1'b1;
               m_hi   <= p_r;
               m_lo   <= p_q;
            end
            m_cnt <= m_cnt - 1;
         end else if (start) begin
            logic [W-1:0] tq;
            logic [W-1:0] tr;
            ref_div(dividend, divisor, signed_op, tq, tr);
            p_q    <= tq;
            p_r    <= tr;
            m_busy <= 1'b1;
            m_cnt  <= 33;
         end
      end
   end

   task automatic cmp(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      cmp("busy", W'(busy), W'(m_busy));
      cmp("done", W'(done), W'(m_done));
      cmp("hi", hi, m_hi);
      cmp("lo", lo, m_lo);
      if (cycles == 100000) begin
         n_bad++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      @(negedge clk);
      start     = 1'b1;
      dividend  = a;
      divisor   = b;
      signed_op = s;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!m_done);
   endtask

   task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic s);
      cur_req = req;
      issue(a, b, s);
      wait_done();
      repeat (2) @(negedge clk);   // R8: outputs held across idle cycles
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 unsigned
      run("R2", 32'd7, 32'd2, 1'b0);
      run("R2", 32'hFFFF_FFFF, 32'd3, 1'b0);
      run("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run("R2", 32'd5, 32'd7, 1'b0);
      run("R2", 32'h8000_0000, 32'hFFFF_FFFE, 1'b0);
      // R3 / R4 signed
      run("R3", 32'hFFFF_FFF9, 32'd2, 1'b1);
      run("R4", 32'd7, 32'hFFFF_FFFE, 1'b1);
      run("R4", 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1);
      run("R3", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
      run("R3", 32'h8000_0000, 32'd1, 1'b1);
      run("R4", 32'h8000_0001, 32'h7FFF_FFFF, 1'b1);
      // R5 zero divisor
      run("R5", 32'd1234, 32'd0, 1'b0);
      run("R5", 32'hFFFF_FF00, 32'd0, 1'b1);
      run("R5", 32'h8000_0000, 32'd0, 1'b1);

      // R7: start while busy carries other operands and must be ignored
      cur_req = "R7";
      issue(32'd100, 32'd9, 1'b0);
      repeat (5) @(negedge clk);
      start = 1'b1; dividend = 32'd55; divisor = 32'd0; signed_op = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (2) @(negedge clk);

      // R9: back-to-back start during the done cycle
      cur_req = "R9";
      issue(32'd1000, 32'd7, 1'b0);
      wait_done();
      start = 1'b1; dividend = 32'hFFFF_FC18; divisor = 32'd7; signed_op = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (2) @(negedge clk);

      // R6 plus R2/R3 coverage on generated operands
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a;
         logic [31:0] b;
         seed = next_rand(seed);
         a    = seed;
         seed = next_rand(seed);
         b    = seed >> (seed[4:0] % 31);
         seed = next_rand(seed);
         run("R6", a, b, seed[0]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule